// File: doc/BRIEF.md
# Tagged Stack Register Window

This block is an integer register file with 32 architectural names, extended for stack-oriented code. Names x1 to x14 are ordinary fixed registers and x0 always reads zero. Names x16 to x31 do not have storage of their own. They view sixteen consecutive words of a larger physical stack array, starting at a movable window base. Two inputs move the base up or down by a fixed step, so a call or a return can expose a fresh set of locals while overlapping the previous ones.

Name x15 is an implicit stack-top alias into that same physical array. Reading it yields the top entry and, when the read port is enabled, pops that entry at the clock edge. Writing it pushes. If one instruction does both, the pop is done first and the push second, so the top entry is replaced. Every stored word carries one extra tag bit that separates tagged values from raw ones. Only a result marked as coming from an object-aware load can set that bit. Every other write stores it cleared.

A small controller state machine tracks the stack fill level with the states ST_EMPTY, ST_PARTIAL and ST_FULL. Its transitions are FIRST_PUSH (ST_EMPTY to ST_PARTIAL), FILL_UP (ST_PARTIAL to ST_FULL), LAST_POP (ST_PARTIAL to ST_EMPTY) and FIRST_POP (ST_FULL to ST_PARTIAL). Any other combination of requests keeps the current state. A stack pointer or window base that would leave the physical array raises an overflow or underflow output for that cycle and leaves the pointer unchanged. Spilling to memory is left to the surrounding core.

Top module: `stkwin_regfile`

## Requirements
- R1: After reset the stack is empty, the window base is 0, and every register name reads data 0 with tag 0.
- R2: x0 always reads data 0 and tag 0. Writes to x0 have no effect.
- R3: x1 to x14 keep their written values, and moving the window does not change them.
- R4: x(16+k) reads and writes physical entry base+k. A shift_out raises the base by STEP (default 8) and a shift_in lowers it by STEP, both taking effect at the clock edge. With both asserted in the same cycle the base does not move and no flag is raised.
- R5: A shift_out when base+STEP would exceed PHYS-16 raises win_ovf in that cycle, and a shift_in when base < STEP raises win_unf in that cycle. In both cases the base is unchanged.
- R6: Reading x15 on either port returns the top entry, physical index count-1, in the same cycle. If either port reads x15 with its enable set, exactly one entry is popped at the edge. A read of x15 with the enable clear does not pop.
- R7: Writing x15 stores the word at physical index count and increments the count.
- R8: When x15 is popped and pushed in the same cycle, the pop is applied first. The top entry is replaced and the count is unchanged. This also works when the stack is full.
- R9: A push while full raises stk_ovf, stores nothing and keeps the count. A pop while empty raises stk_unf, reads data 0 with tag 0 and keeps the count. Flags are ordered {stk_ovf, stk_unf, win_ovf, win_unf}.
- R10: A write stores tag = ld_tag when wr_is_load=1, and tag 0 otherwise. Reads return the stored tag.
- R11: The stack and the window share one physical array. A pushed word is visible through x(16+k) when base+k equals its index, and a pop does not erase the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_en | input | 1 | Port A read is a real use (enables the pop on x15) |
| rd_a_addr | input | 5 | Port A register name |
| rd_a_data | output | XLEN | Port A data |
| rd_a_tag | output | 1 | Port A tag bit |
| rd_b_en | input | 1 | Port B read is a real use (enables the pop on x15) |
| rd_b_addr | input | 5 | Port B register name |
| rd_b_data | output | XLEN | Port B data |
| rd_b_tag | output | 1 | Port B tag bit |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register name |
| wr_data | input | XLEN | Write data |
| wr_is_load | input | 1 | Write comes from an object-aware load |
| ld_tag | input | 1 | Tag delivered by the load path |
| shift_out | input | 1 | Move the window base up by STEP |
| shift_in | input | 1 | Move the window base down by STEP |
| stk_ovf | output | 1 | Push refused, stack full |
| stk_unf | output | 1 | Pop refused, stack empty |
| win_ovf | output | 1 | Window move refused at the top |
| win_unf | output | 1 | Window move refused at the bottom |

## Verification
Read data and tags are combinational from the current state and address, so they are due in the same cycle the address is driven. The four flags are also combinational and are due in the cycle of the request. Pointer, base and storage updates land at the following edge, so they show up in the next operation's reads. The bench drives every operation just after a falling edge and compares two nanoseconds later, still ahead of the rising edge. Each effect of an operation is therefore checked through the reads of the operation that follows it.

// File: rtl/stkwin_pkg.sv
package stkwin_pkg;
    localparam int unsigned REG_AW    = 5;
    localparam int unsigned WIN_REGS  = 16;
    localparam int unsigned NFIX      = 15;
    localparam logic [REG_AW-1:0] ALIAS_REG = 5'd15;
    localparam logic [REG_AW-1:0] WIN_FIRST = 5'd16;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } stk_state_e;
endpackage

// File: rtl/stkwin_ctrl.sv
// Stack fill state machine and window base. PHYS must be at least 2 and
// STEP must not exceed PHYS-16.
module stkwin_ctrl
    import stkwin_pkg::*;
#(
    parameter int unsigned PHYS = 64,
    parameter int unsigned STEP = 8,
    localparam int unsigned IDX_W = $clog2(PHYS),
    localparam int unsigned CNT_W = $clog2(PHYS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_req,
    input  logic             push_req,
    input  logic             shift_out,
    input  logic             shift_in,
    output logic [CNT_W-1:0] sp_cnt,
    output logic             tos_valid,
    output logic [IDX_W-1:0] tos_idx,
    output logic [IDX_W-1:0] push_idx,
    output logic             push_ok,
    output logic [IDX_W-1:0] win_base,
    output logic             stk_ovf,
    output logic             stk_unf,
    output logic             win_ovf,
    output logic             win_unf
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PHYS);
    localparam logic [IDX_W-1:0] OUT_LIM  = IDX_W'(PHYS - WIN_REGS - STEP);
    localparam logic [IDX_W-1:0] STEP_C   = IDX_W'(STEP);

    stk_state_e       state, state_nx;
    logic             can_pop, room_left, pop_ok;
    logic [CNT_W-1:0] cnt_mid, cnt_nx, cnt_dec;
    logic             mv_out, mv_in;
    logic [IDX_W-1:0] base_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_EMPTY;
            sp_cnt <= '0;
        end else begin
            state  <= state_nx;
            sp_cnt <= cnt_nx;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        can_pop   = 1'b0;
        room_left = 1'b1;
        unique case (state)
            ST_EMPTY:   begin can_pop = 1'b0; room_left = 1'b1; end
            ST_PARTIAL: begin can_pop = 1'b1; room_left = 1'b1; end
            ST_FULL:    begin can_pop = 1'b1; room_left = 1'b0; end
            default:    begin can_pop = 1'b0; room_left = 1'b1; end
        endcase
        pop_ok    = pop_req & can_pop;
        stk_unf   = pop_req & ~can_pop;
        // pop is applied before push, so a pop frees room for the push
        push_ok   = push_req & (room_left | pop_ok);
        stk_ovf   = push_req & ~(room_left | pop_ok);
        cnt_mid   = sp_cnt - CNT_W'(pop_ok);
        cnt_nx    = cnt_mid + CNT_W'(push_ok);
        cnt_dec   = sp_cnt - CNT_W'(1);
        push_idx  = cnt_mid[IDX_W-1:0];
        tos_idx   = cnt_dec[IDX_W-1:0];
        tos_valid = can_pop;
    end

    // Next-state transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY:   if (push_ok) state_nx = ST_PARTIAL;               // FIRST_PUSH
            ST_PARTIAL: begin
                if (cnt_nx == FULL_CNT)  state_nx = ST_FULL;              // FILL_UP
                else if (cnt_nx == '0)   state_nx = ST_EMPTY;             // LAST_POP
            end
            ST_FULL:    if (cnt_nx != FULL_CNT) state_nx = ST_PARTIAL;    // FIRST_POP
            default:    state_nx = ST_EMPTY;
        endcase
    end

    // Window base movement
    always_comb begin
        mv_out  = shift_out & ~shift_in;
        mv_in   = shift_in & ~shift_out;
        win_ovf = mv_out & (win_base > OUT_LIM);
        win_unf = mv_in & (win_base < STEP_C);
        base_nx = win_base;
        if (mv_out && !win_ovf) base_nx = win_base + STEP_C;
        else if (mv_in && !win_unf) base_nx = win_base - STEP_C;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_base <= '0;
        else        win_base <= base_nx;
    end
endmodule

// File: rtl/stkwin_store.sv
// Tagged storage: fixed registers and the shared physical stack array.
module stkwin_store
    import stkwin_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned PHYS = 64,
    localparam int unsigned IDX_W  = $clog2(PHYS),
    localparam int unsigned WORD_W = XLEN + 1,
    localparam int unsigned FIX_AW = $clog2(NFIX)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0][REG_AW-1:0]       rd_addr,
    output logic [1:0][WORD_W-1:0]       rd_word,
    input  logic [IDX_W-1:0]             win_base,
    input  logic                         tos_valid,
    input  logic [IDX_W-1:0]             tos_idx,
    input  logic [IDX_W-1:0]             push_idx,
    input  logic                         push_ok,
    input  logic                         wr_en,
    input  logic [REG_AW-1:0]            wr_addr,
    input  logic [WORD_W-1:0]            wr_word
);
    logic [WORD_W-1:0] phys_q [PHYS];
    logic [WORD_W-1:0] fix_q  [NFIX];

    for (genvar gp = 0; gp < 2; gp++) begin : g_rd
        logic [REG_AW-1:0] ra;
        always_comb begin
            ra = rd_addr[gp];
            if (ra == '0)
                rd_word[gp] = '0;
            else if (ra < ALIAS_REG)
                rd_word[gp] = fix_q[ra[FIX_AW-1:0]];
            else if (ra == ALIAS_REG)
                rd_word[gp] = tos_valid ? phys_q[tos_idx] : '0;
            else
                rd_word[gp] = phys_q[win_base + IDX_W'(ra - WIN_FIRST)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS; i++) phys_q[i] <= '0;
            for (int j = 0; j < NFIX; j++) fix_q[j] <= '0;
        end else if (wr_en) begin
            if (wr_addr == ALIAS_REG) begin
                if (push_ok) phys_q[push_idx] <= wr_word;
            end else if (wr_addr >= WIN_FIRST) begin
                phys_q[win_base + IDX_W'(wr_addr - WIN_FIRST)] <= wr_word;
            end else if (wr_addr != '0) begin
                fix_q[wr_addr[FIX_AW-1:0]] <= wr_word;
            end
        end
    end
endmodule

// File: rtl/stkwin_regfile.sv
module stkwin_regfile
    import stkwin_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned PHYS = 64,
    parameter int unsigned STEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_a_en,
    input  logic [4:0]      rd_a_addr,
    output logic [XLEN-1:0] rd_a_data,
    output logic            rd_a_tag,
    input  logic            rd_b_en,
    input  logic [4:0]      rd_b_addr,
    output logic [XLEN-1:0] rd_b_data,
    output logic            rd_b_tag,
    input  logic            wr_en,
    input  logic [4:0]      wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic            wr_is_load,
    input  logic            ld_tag,
    input  logic            shift_out,
    input  logic            shift_in,
    output logic            stk_ovf,
    output logic            stk_unf,
    output logic            win_ovf,
    output logic            win_unf
);
    localparam int unsigned IDX_W  = $clog2(PHYS);
    localparam int unsigned CNT_W  = $clog2(PHYS + 1);
    localparam int unsigned WORD_W = XLEN + 1;

    logic                   pop_req, push_req, push_ok, tos_valid;
    logic [CNT_W-1:0]       sp_cnt;
    logic [IDX_W-1:0]       tos_idx, push_idx, win_base;
    logic [1:0][REG_AW-1:0] rd_addr;
    logic [1:0][WORD_W-1:0] rd_word;
    logic [WORD_W-1:0]      wr_word;

    assign pop_req  = (rd_a_en && rd_a_addr == ALIAS_REG) || (rd_b_en && rd_b_addr == ALIAS_REG);
    assign push_req = wr_en && (wr_addr == ALIAS_REG);
    // only the object-aware load path may set the tag
    assign wr_word  = {wr_is_load & ld_tag, wr_data};
    assign rd_addr  = {rd_b_addr, rd_a_addr};
    assign {rd_a_tag, rd_a_data} = rd_word[0];
    assign {rd_b_tag, rd_b_data} = rd_word[1];

    stkwin_ctrl #(.PHYS(PHYS), .STEP(STEP)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .pop_req(pop_req), .push_req(push_req),
        .shift_out(shift_out), .shift_in(shift_in),
        .sp_cnt(sp_cnt), .tos_valid(tos_valid), .tos_idx(tos_idx),
        .push_idx(push_idx), .push_ok(push_ok), .win_base(win_base),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf),
        .win_ovf(win_ovf), .win_unf(win_unf)
    );

    stkwin_store #(.XLEN(XLEN), .PHYS(PHYS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .rd_word(rd_word),
        .win_base(win_base), .tos_valid(tos_valid), .tos_idx(tos_idx),
        .push_idx(push_idx), .push_ok(push_ok),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word)
    );
endmodule

// File: rtl/stkwin_chk.sv
module stkwin_chk #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned PHYS = 64,
    localparam int unsigned IDX_W = $clog2(PHYS),
    localparam int unsigned CNT_W = $clog2(PHYS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       rd_a_addr,
    input logic [XLEN-1:0]  rd_a_data,
    input logic             rd_a_tag,
    input logic             wr_en,
    input logic [4:0]       wr_addr,
    input logic             stk_ovf,
    input logic             stk_unf,
    input logic             win_ovf,
    input logic             win_unf,
    input logic [CNT_W-1:0] sp_cnt,
    input logic [IDX_W-1:0] win_base
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PHYS);
    localparam logic [IDX_W-1:0] BASE_TOP = IDX_W'(PHYS - 16);

    // R2
    x0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == 5'd0) |-> (rd_a_data == '0 && !rd_a_tag));
    // R9
    stk_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |=> (sp_cnt == $past(sp_cnt)));
    // R9
    stk_unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_unf && !(wr_en && wr_addr == 5'd15)) |=> $stable(sp_cnt));
    // R9
    stk_flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_ovf && stk_unf));
    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_cnt <= FULL_CNT);
    // R5
    win_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf |=> $stable(win_base));
    // R5
    win_unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_unf |=> $stable(win_base));
    // R5
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_base <= BASE_TOP);
endmodule

bind stkwin_regfile stkwin_chk #(.XLEN(XLEN), .PHYS(PHYS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data), .rd_a_tag(rd_a_tag),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .stk_ovf(stk_ovf), .stk_unf(stk_unf), .win_ovf(win_ovf), .win_unf(win_unf),
    .sp_cnt(sp_cnt), .win_base(win_base)
);

// File: tb/sim_stkwin_regfile.sv
`timescale 1ns/1ps
module sim_stkwin_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_a_en = 0, rd_b_en = 0, wr_en = 0, wr_is_load = 0, ld_tag = 0;
    logic        shift_out = 0, shift_in = 0;
    logic [4:0]  rd_a_addr = 0, rd_b_addr = 0, wr_addr = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        rd_a_tag, rd_b_tag, stk_ovf, stk_unf, win_ovf, win_unf;
    int          n_tests = 0, n_fail = 0;
    bit          done = 0;

    typedef struct {
        logic [31:0] a; logic at;
        logic [31:0] b; logic bt;
        logic [3:0]  fl;
        string       req;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    stkwin_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data), .rd_a_tag(rd_a_tag),
        .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .rd_b_tag(rd_b_tag),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_is_load(wr_is_load), .ld_tag(ld_tag),
        .shift_out(shift_out), .shift_in(shift_in),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf), .win_ovf(win_ovf), .win_unf(win_unf)
    );

    // driver: one operation per cycle, expected same-cycle outputs queued
    task automatic op(input logic ae, input logic [4:0] aa, input logic be, input logic [4:0] ba,
                      input logic we, input logic [4:0] wa, input logic [31:0] wd,
                      input logic wl, input logic lt, input logic so, input logic si,
                      input logic [31:0] ea, input logic eat, input logic [31:0] eb, input logic ebt,
                      input logic [3:0] efl, input string req);
        exp_t e;
        @(negedge clk);
        rd_a_en = ae; rd_a_addr = aa; rd_b_en = be; rd_b_addr = ba;
        wr_en = we; wr_addr = wa; wr_data = wd; wr_is_load = wl; ld_tag = lt;
        shift_out = so; shift_in = si;
        e.a = ea; e.at = eat; e.b = eb; e.bt = ebt; e.fl = efl; e.req = req;
        q.push_back(e);
    endtask

    // monitor: compares between the falling and the next rising edge
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_tests++;
                if (rd_a_data !== e.a || rd_a_tag !== e.at || rd_b_data !== e.b || rd_b_tag !== e.bt ||
                    {stk_ovf, stk_unf, win_ovf, win_unf} !== e.fl) begin
                    n_fail++;
                    $display("FAIL %s: got a=%h/%b b=%h/%b fl=%b expected a=%h/%b b=%h/%b fl=%b",
                             e.req, rd_a_data, rd_a_tag, rd_b_data, rd_b_tag,
                             {stk_ovf, stk_unf, win_ovf, win_unf}, e.a, e.at, e.b, e.bt, e.fl);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        op(0,16,0,31, 0,0,0,0,0, 0,0, 0,0,0,0, 4'b0000, "R1");
        op(0,15,0,5,  0,0,0,0,0, 0,0, 0,0,0,0, 4'b0000, "R1");
        // R2 x0 write ignored
        op(0,0,0,0,   1,0,32'd5,0,0, 0,0, 0,0,0,0, 4'b0000, "R2");
        op(0,0,0,5,   1,5,32'h1111,0,1, 0,0, 0,0,0,0, 4'b0000, "R2");
        // R3 fixed, R10 tag from arithmetic cleared even with ld_tag high
        op(0,5,0,6,   1,6,32'h2222,1,1, 0,0, 32'h1111,0,0,0, 4'b0000, "R3");
        op(0,6,0,7,   1,7,32'h3333,0,1, 0,0, 32'h2222,1,0,0, 4'b0000, "R10");
        op(0,7,0,0,   0,0,0,0,0, 0,0, 32'h3333,0,0,0, 4'b0000, "R10");
        // R4 window mapping and movement
        op(0,0,0,0,   1,17,32'hA1,0,0, 0,0, 0,0,0,0, 4'b0000, "R4");
        op(0,0,0,0,   1,25,32'hA9,0,0, 0,0, 0,0,0,0, 4'b0000, "R4");
        op(0,25,0,0,  0,0,0,0,0, 1,0, 32'hA9,0,0,0, 4'b0000, "R4");
        op(0,17,0,16, 1,31,32'hBF,0,0, 0,0, 32'hA9,0,0,0, 4'b0000, "R4");
        op(0,31,0,0,  0,0,0,0,0, 0,1, 32'hBF,0,0,0, 4'b0000, "R4");
        // R5 bottom limit, R3 fixed unaffected by moves
        op(0,17,0,5,  0,0,0,0,0, 0,1, 32'hA1,0,32'h1111,0, 4'b0001, "R5");
        op(0,17,0,31, 0,0,0,0,0, 0,0, 32'hA1,0,0,0, 4'b0000, "R5");
        for (int k = 0; k < 6; k++)
            op(0,16,0,0, 0,0,0,0,0, 1,0, 0,0,0,0, 4'b0000, "R4");
        op(0,17,0,0,  1,31,32'hCC,0,0, 0,0, 0,0,0,0, 4'b0000, "R4");
        // R5 top limit
        op(0,31,0,0,  0,0,0,0,0, 1,0, 32'hCC,0,0,0, 4'b0010, "R5");
        op(0,31,0,0,  0,0,0,0,0, 1,1, 32'hCC,0,0,0, 4'b0000, "R4");
        op(0,31,0,0,  0,0,0,0,0, 0,0, 32'hCC,0,0,0, 4'b0000, "R5");
        for (int k = 0; k < 6; k++)
            op(0,16,0,0, 0,0,0,0,0, 0,1, 0,0,0,0, 4'b0000, "R4");
        op(0,17,0,5,  0,0,0,0,0, 0,0, 32'hA1,0,32'h1111,0, 4'b0000, "R3");
        // R9 underflow
        op(1,15,0,0,  0,0,0,0,0, 0,0, 0,0,0,0, 4'b0100, "R9");
        // R7 push, R11 sharing
        op(0,15,0,0,  1,15,32'h100,0,0, 0,0, 0,0,0,0, 4'b0000, "R7");
        op(0,16,0,15, 1,15,32'h200,1,1, 0,0, 32'h100,0,32'h100,0, 4'b0000, "R11");
        op(0,17,0,15, 0,0,0,0,0, 0,0, 32'h200,1,32'h200,1, 4'b0000, "R10");
        // R6 pop and peek
        op(1,15,0,0,  0,0,0,0,0, 0,0, 32'h200,1,0,0, 4'b0000, "R6");
        op(0,15,0,17, 0,0,0,0,0, 0,0, 32'h100,0,32'h200,1, 4'b0000, "R6");
        // R8 pop then push
        op(1,15,0,0,  1,15,32'h300,0,0, 0,0, 32'h100,0,0,0, 4'b0000, "R8");
        op(0,15,0,16, 0,0,0,0,0, 0,0, 32'h300,0,32'h300,0, 4'b0000, "R8");
        // R7 fill to the top
        for (int i = 1; i < 64; i++)
            op(0,15,0,0, 1,15,32'h1000 + i,0,0, 0,0,
               (i == 1) ? 32'h300 : 32'h1000 + i - 1,0,0,0, 4'b0000, "R7");
        // R9 overflow
        op(0,15,0,0,  1,15,32'hDEAD,0,0, 0,0, 32'h103F,0,0,0, 4'b1000, "R9");
        op(0,15,0,16, 0,0,0,0,0, 0,0, 32'h103F,0,32'h300,0, 4'b0000, "R9");
        // R8 replace while full
        op(1,15,0,0,  1,15,32'h5555,1,1, 0,0, 32'h103F,0,0,0, 4'b0000, "R8");
        // R6 both ports pop once
        op(1,15,1,15, 0,0,0,0,0, 0,0, 32'h5555,1,32'h5555,1, 4'b0000, "R6");
        for (int i = 62; i >= 1; i--)
            op(1,15,0,0, 0,0,0,0,0, 0,0, 32'h1000 + i,0,0,0, 4'b0000, "R6");
        op(1,15,0,0,  0,0,0,0,0, 0,0, 32'h300,0,0,0, 4'b0000, "R6");
        op(1,15,0,0,  0,0,0,0,0, 0,0, 0,0,0,0, 4'b0100, "R9");
        op(0,16,0,0,  0,0,0,0,0, 0,0, 32'h300,0,0,0, 4'b0000, "R11");
        op(0,0,0,0,   0,0,0,0,0, 0,0, 0,0,0,0, 4'b0000, "R2");
        repeat (3) @(negedge clk);
        n_tests++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1: got %0d pending items expected 0", q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule